// File: doc/BRIEF.md
# Cascaded Interval Timer with Carrier Capture

This block is a real-time-clock style interval timer. A prescaler divides the system clock down to a tick. The tick drives a low counter (14 bits by default) and a high counter (7 bits by default), which together form one long interval. When both counters equal their programmed match values on the same tick, both clear and a sticky interrupt flag is raised. Software clears the flag with an acknowledge pulse or by writing zero to the status register.

In capture mode the high counter is frozen. The low counter becomes a free-running up counter that restarts on every rising edge of an event input. On carrier edges it stores timestamps into two capture registers. A phase bit chooses which edge loads which register. A single-shot bit makes each capture register load only once until the control register is written again.

A small register port covers configuration and readback. Writes are taken on the clock edge. Read data is registered and reflects the addressed state one cycle later. The register map is: 0 control (bit0 run, bits 2:1 divide select, bit3 capture mode, bit4 single-shot, bit5 phase); 1 status (bit0 flag); 2 high match / high counter; 3 upper low match / low counter bits above 7; 4 lower low match / low counter bits 7:0; 5 and 6 capture A low/high byte; 7 and 8 capture B low/high byte.

Top module: `rtc_interval_timer`

## Requirements
- R1: While control bit0 (run) is 0, both counters hold zero. Reading addresses 2, 3 and 4 then returns 0.
- R2: In interval mode the low counter advances once every 2^(5+sel) system clocks, where sel is control bits 2:1. This gives ratios of 32, 64, 128 and 256.
- R3: A match occurs on a tick where the low counter equals the low match and the high counter equals the high match. Both counters then clear, so the interval is (2^LO_W × high match + low match + 1) ticks.
- R4: On a tick without a match where the low counter is all ones, the low counter wraps to 0 and the high counter increments.
- R5: A match sets the status flag, and the irq output follows the flag.
- R6: The flag clears on an irq_ack pulse or on a write of 0 to status bit0. Writing 1 has no effect, and a match in the same cycle wins over a clear.
- R7: Writes to addresses 2, 3 and 4 set the high match, the low match bits above 7 and the low match bits 7:0. Reads of those addresses return the live high counter, the upper low-counter bits and the lower low-counter byte.
- R8: In capture mode the high counter is frozen and no match occurs. The low counter ticks every 2^sel clocks and clears on each rising edge of the event input, after a two-flop synchronizer and an edge detector.
- R9: In capture mode a detected edge stores the low counter value held before that edge's clear. With phase=0 a rising edge loads capture A and a falling edge loads capture B; with phase=1 the edges are swapped.
- R10: With single-shot set, each capture register loads only once, then holds until the next write to the control register.
- R11: Read data appears on rdata one clock after addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| evt_in | input | 1 | Asynchronous event / carrier input |
| irq | output | 1 | Interrupt flag output |

## Verification
The interrupt flag rises on the clock edge of the matching tick. The bench therefore measures intervals as the distance between two flag rises, which cancels the prescaler start phase, and compares that distance with the exact period formula. Event edges pass through three registers before they clear or capture. Both edges of a pulse see the same delay, so a capture equals the spacing between input transitions minus one, and the bench drives those transitions on falling clock edges. Register reads are sampled one full clock after the address is driven, which matches the single register stage on rdata. Counter readbacks are taken at points where the tick count since the last match is known exactly.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_STAT  = 4'd1,
    A_HI    = 4'd2,
    A_LO_UP = 4'd3,
    A_LO_LN = 4'd4,
    A_CAPA0 = 4'd5,
    A_CAPA1 = 4'd6,
    A_CAPB0 = 4'd7,
    A_CAPB1 = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic       phase;
    logic       single;
    logic       cap;
    logic [1:0] sel;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int BASE_LOG2 = 5,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cap_mode,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  int               k;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    k    = cap_mode ? int'(sel) : BASE_LOG2 + int'(sel);
    mask = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < k) mask[i] = 1'b1;
    end
    tick = run && ((cnt & mask) == mask);
  end
endmodule

// File: rtl/wt_cascade.sv
module wt_cascade #(
  parameter int LO_W = 14,
  parameter int HI_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            cap_mode,
  input  logic            tick,
  input  logic            clr,
  input  logic [LO_W-1:0] lo_match,
  input  logic [HI_W-1:0] hi_match,
  output logic [LO_W-1:0] low,
  output logic [HI_W-1:0] high,
  output logic            hit
);
  localparam logic [LO_W-1:0] LO_ALL = '1;

  assign hit = run && !cap_mode && tick && (low == lo_match) && (high == hi_match);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      low  <= '0;
      high <= '0;
    end else if (cap_mode) begin
      if (clr)       low <= '0;
      else if (tick) low <= low + LO_W'(1);
    end else if (tick) begin
      if (hit) begin
        low  <= '0;
        high <= '0;
      end else if (low == LO_ALL) begin
        low  <= '0;
        high <= high + HI_W'(1);
      end else begin
        low <= low + LO_W'(1);
      end
    end
  end
endmodule

// File: rtl/wt_capture.sv
module wt_capture #(
  parameter int LO_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            phase,
  input  logic            single,
  input  logic            arm,
  input  logic            evt_in,
  input  logic [LO_W-1:0] low,
  output logic            clr,
  output logic [LO_W-1:0] cap_a,
  output logic [LO_W-1:0] cap_b
);
  logic s1, s2, s3;
  logic rise, fall, a_evt, b_evt;
  logic a_full, b_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= evt_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
  assign a_evt = active && (phase ? fall : rise);
  assign b_evt = active && (phase ? rise : fall);
  assign clr   = active && rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a  <= '0;
      cap_b  <= '0;
      a_full <= 1'b0;
      b_full <= 1'b0;
    end else begin
      if (arm) begin
        a_full <= 1'b0;
        b_full <= 1'b0;
      end
      if (a_evt && !(single && a_full)) begin
        cap_a  <= low;
        a_full <= 1'b1;
      end
      if (b_evt && !(single && b_full)) begin
        cap_b  <= low;
        b_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_interval_timer.sv
module rtc_interval_timer
  import wt_pkg::*;
#(
  parameter int LO_W      = 14,
  parameter int HI_W      = 7,
  parameter int BASE_LOG2 = 5,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              irq_ack,
  input  logic              evt_in,
  output logic              irq
);
  localparam int UP_W = LO_W - DATA_W;

  ctrl_t           ctl;
  logic [LO_W-1:0] lo_m;
  logic [HI_W-1:0] hi_m;
  logic [LO_W-1:0] cnt_low;
  logic [HI_W-1:0] cnt_high;
  logic [LO_W-1:0] cap_a, cap_b;
  logic            tick, hit, evt_clr, arm, flag_q;
  logic            ctl_en, ctl_cap;
  logic            stat_clr;

  assign ctl_en   = ctl.run;
  assign ctl_cap  = ctl.cap;
  assign arm      = wr_en && (addr == A_CTRL);
  assign stat_clr = wr_en && (addr == A_STAT) && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      lo_m <= '0;
      hi_m <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctl <= ctrl_t'(wdata[5:0]);
        A_HI:    hi_m <= HI_W'(wdata);
        A_LO_UP: lo_m[LO_W-1:DATA_W] <= UP_W'(wdata);
        A_LO_LN: lo_m[DATA_W-1:0] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      flag_q <= 1'b0;
    else if (hit)                 flag_q <= 1'b1;
    else if (irq_ack || stat_clr) flag_q <= 1'b0;
  end

  assign irq = flag_q;

  wt_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .run(ctl.run), .cap_mode(ctl.cap),
    .sel(SEL_W'(ctl.sel)), .tick(tick)
  );

  wt_cascade #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctl.run), .cap_mode(ctl.cap), .tick(tick),
    .clr(evt_clr), .lo_match(lo_m), .hi_match(hi_m),
    .low(cnt_low), .high(cnt_high), .hit(hit)
  );

  wt_capture #(.LO_W(LO_W)) u_cap (
    .clk(clk), .rst(rst), .active(ctl.run && ctl.cap), .phase(ctl.phase),
    .single(ctl.single), .arm(arm), .evt_in(evt_in), .low(cnt_low),
    .clr(evt_clr), .cap_a(cap_a), .cap_b(cap_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_CTRL:  rdata <= DATA_W'(ctl);
        A_STAT:  rdata <= DATA_W'(flag_q);
        A_HI:    rdata <= DATA_W'(cnt_high);
        A_LO_UP: rdata <= DATA_W'(cnt_low[LO_W-1:DATA_W]);
        A_LO_LN: rdata <= cnt_low[DATA_W-1:0];
        A_CAPA0: rdata <= cap_a[DATA_W-1:0];
        A_CAPA1: rdata <= DATA_W'(cap_a[LO_W-1:DATA_W]);
        A_CAPB0: rdata <= cap_b[DATA_W-1:0];
        A_CAPB1: rdata <= DATA_W'(cap_b[LO_W-1:DATA_W]);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int LO_W = 14,
  parameter int HI_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            cap,
  input logic [LO_W-1:0] low,
  input logic [HI_W-1:0] high,
  input logic            hit,
  input logic            flag,
  input logic            irq_ack,
  input logic            rise_clr
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (low == '0 && high == '0));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !hit) |=> !flag);

  p_hi_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (en && cap) |=> $stable(high));

  p_rise_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (en && cap && rise_clr) |=> (low == '0));
endmodule

bind rtc_interval_timer wt_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst(rst), .en(ctl_en), .cap(ctl_cap), .low(cnt_low),
  .high(cnt_high), .hit(hit), .flag(flag_q), .irq_ack(irq_ack),
  .rise_clr(evt_clr)
);

// File: tb/sim_rtc_interval_timer.sv
module sim_rtc_interval_timer;
  localparam int LW = 10;
  localparam int HW = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_ack = 1'b0;
  logic       evt_in = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_interval_timer #(.LO_W(LW), .HI_W(HW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_ack(irq_ack), .evt_in(evt_in), .irq(irq)
  );

  function automatic int exp_period(int lo, int hi, int sel);
    return ((1 << LW) * hi + lo + 1) * (1 << (5 + sel));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    addr = 4'(a);
    @(negedge clk);
    v = int'(rdata);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_irq(output int t);
    while (!irq) @(negedge clk);
    t = cyc;
  endtask

  task automatic set_match(int lo, int hi);
    wr(2, hi); wr(3, lo >> 8); wr(4, lo & 255);
  endtask

  task automatic pulse(int h, int l);
    @(negedge clk); evt_in = 1'b1;
    repeat (h) @(negedge clk);
    evt_in = 1'b0;
    repeat (l - 1) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, t1, t2, lo, sel, h, l, a0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 R1 reset state
    rd(4, v); check("R11 reset low", v, 0);
    check("R5 reset irq", int'(irq), 0);

    // R2 R3 interval with random ratios and low matches
    for (int i = 0; i < 6; i++) begin
      sel = (i < 4) ? i : int'($urandom_range(0, 1));
      lo  = (i < 4) ? 3 + i : int'($urandom_range(2, 30));
      wr(0, 0);
      set_match(lo, 0);
      wr(0, (sel << 1) | 1);
      wait_irq(t1); ack();
      wait_irq(t2);
      check("R2 R3 period", t2 - t1, exp_period(lo, 0, sel));
      ack();
      check("R6 ack clears", int'(irq), 0);
    end

    // R4 R7 cascade with high match 1
    wr(0, 0);
    set_match(3, 1);
    wr(0, 1);
    wait_irq(t1);
    repeat (1026 * 32 + 10) @(negedge clk);
    rd(2, v); check("R4 R7 high counter", v, 1);
    rd(4, v); check("R7 low byte", v, 2);
    rd(3, v); check("R7 low upper", v, 0);
    // R6 status write 1 has no effect, write 0 clears
    wr(1, 1); check("R6 write one keeps", int'(irq), 1);
    wr(1, 0); check("R6 status clear", int'(irq), 0);
    wait_irq(t2);
    check("R3 long period", t2 - t1 + 0, exp_period(3, 1, 0) - (t1 - t1));
    // R1 disable clears counters
    repeat (50) @(negedge clk);
    wr(0, 0);
    rd(4, v); check("R1 low zero", v, 0);
    rd(2, v); check("R1 high zero", v, 0);
    ack();

    // R8 R9 capture, phase 0 and 1, random widths
    for (int i = 0; i < 6; i++) begin
      int ph;
      ph = i & 1;
      h  = int'($urandom_range(4, 200));
      l  = int'($urandom_range(4, 200));
      wr(0, (ph << 5) | 8 | 1);
      pulse(5, 7);
      pulse(h, l);
      @(negedge clk); evt_in = 1'b1;
      repeat (8) @(negedge clk);
      rd(5, v); rd(6, a0); v = v + (a0 << 8);
      check(ph ? "R9 phase1 A fall" : "R9 phase0 A rise", v, ph ? h - 1 : h + l - 1);
      rd(7, v); rd(8, a0); v = v + (a0 << 8);
      check(ph ? "R9 phase1 B rise" : "R9 phase0 B fall", v, ph ? h + l - 1 : h - 1);
      rd(2, v); check("R8 high frozen", v, 0);
      check("R8 no irq", int'(irq), 0);
      evt_in = 1'b0;
      repeat (6) @(negedge clk);
    end

    // R8 capture divide 2^sel with sel=2
    wr(0, (2 << 1) | 8 | 1);
    pulse(8, 8);
    pulse(40, 8);
    repeat (6) @(negedge clk);
    rd(7, v); rd(8, a0); v = v + (a0 << 8);
    checks++;
    if (v != 9 && v != 10) begin
      fails++;
      $display("FAIL R8 divided capture: actual %0d expected 9 or 10", v);
    end

    // R10 single-shot holds until control write
    wr(0, 16 | 8 | 1);
    pulse(30, 20);
    repeat (6) @(negedge clk);
    rd(5, a0); rd(7, v);
    check("R10 first B", v, 29);
    pulse(50, 20);
    repeat (6) @(negedge clk);
    rd(5, v); check("R10 A held", v, a0);
    rd(7, v); check("R10 B held", v, 29);
    wr(0, 16 | 8 | 1);
    pulse(60, 20);
    repeat (6) @(negedge clk);
    rd(7, v); check("R10 rearmed B", v, 59);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule